// File: doc/BRIEF.md
# Packed SIMD Left Shift Insert Unit

This block shifts every lane of a 128-bit packed vector left by an immediate count. The vector can be treated as sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Bits never move from one lane into the next. Bits pushed past the top of a lane are lost. In plain mode the vacated low bits of each lane become zero. In insert mode those low bits are taken from the matching lane of a second (destination) vector, so the shifted source is merged over the old destination contents.

The lane size and the shift count both come from two immediate fields: a 4-bit high part and a 3-bit low part. The highest set bit of the high part selects the lane size. The count is the 7-bit concatenation of the two fields minus the lane width. A width bit selects either the full 128-bit vector or only its low 64 bits; in the narrow case the upper half of the result is cleared.

Encodings that cannot be executed raise an illegal flag and produce a zero result. Operands enter through a valid/ready handshake, and each result appears one cycle after it is accepted.

Top module: `simd_shl_insert_unit`

## Requirements
- R1: The lane width is chosen by the most significant set bit of `imm_hi`: bit 0 selects 8, bit 1 selects 16, bit 2 selects 32, bit 3 selects 64 bits.
- R2: The shift count equals the unsigned 7-bit value {`imm_hi`, `imm_lo`} minus the lane width, so it always lies in the range 0 to width-1.
- R3: With `ins_mode` = 0, each lane of the result is the matching source lane shifted left by the count, with zeros in the vacated low bits. Bits shifted past the top of a lane are discarded, and no bit crosses into a neighbouring lane.
- R4: With `ins_mode` = 1, the low count bits of each result lane come from the matching lane of `dst_vec`, and the bits above them come from the source lane shifted left by the count.
- R5: In insert mode, a count of 0 returns the source lane unchanged.
- R6: With `q_full` = 0, result bits 127:64 are zero. With `q_full` = 1, all 128 bits are computed.
- R7: If `imm_hi[3]` = 1 while `q_full` = 0, or if `imm_hi` = 0, then `out_illegal` is 1 and `out_result` is all zeros. Otherwise `out_illegal` is 0.
- R8: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result is presented with `out_valid` = 1 from the next cycle. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` = 1 and `out_ready` = 0, the output stays unchanged.
- R9: During and right after a synchronous active-low reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_vec | input | 128 | Vector whose lanes are shifted |
| dst_vec | input | 128 | Vector that supplies the low lane bits in insert mode |
| q_full | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| ins_mode | input | 1 | 1: insert mode, 0: plain shift |
| imm_hi | input | 4 | High immediate field (lane width and high part of count) |
| imm_lo | input | 3 | Low immediate field (low part of count) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Shifted vector |
| out_illegal | output | 1 | Encoding could not be executed |

## Verification
A wrong lane-width or count decode changes the result of the very next operation. It shows up as bits that spread across lane boundaries, or as a shift whose size is off by one lane width. A fault in the insert mask shows only in insert mode, where the wrong number of destination bits survives in each lane. A fault in the output register or handshake shows as a result that changes while the consumer is stalled, or that arrives a cycle early or late. The bench compares every result with a bit-level model one cycle after it is accepted, and it stalls the consumer to catch a lost or overwritten result.

// File: rtl/simd_shl_pkg.sv
// Shared constants and types for the packed left-shift unit.
// Assumes a 128-bit vector split into power-of-two lanes of 8 to 64 bits.
package simd_shl_pkg;
    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int CNT_W     = 6;
    localparam int NUM_SIZES = 4;
    localparam int MIN_LANE  = 8;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_sel_e;
endpackage

// File: rtl/simd_shl_decode.sv
// Turns the two immediate fields into a lane size, a shift count and an
// illegal flag. Assumes the fields belong to a left-shift operation.
module simd_shl_decode
    import simd_shl_pkg::*;
(
    input  logic [3:0]       imm_hi,
    input  logic [2:0]       imm_lo,
    input  logic             q_full,
    output lane_sel_e        lane_sel,
    output logic [CNT_W-1:0] shift_cnt,
    output logic             illegal
);
    logic [6:0] imm_cat;
    logic [6:0] lane_w;
    logic [6:0] diff;

    // Lane size from the highest set bit of the high field (R1)
    always_comb begin
        casez (imm_hi)
            4'b1???: lane_sel = LANE_B64;
            4'b01??: lane_sel = LANE_B32;
            4'b001?: lane_sel = LANE_B16;
            default: lane_sel = LANE_B8;
        endcase
    end

    // Shift count is the concatenated immediate less the lane width (R2)
    always_comb begin
        imm_cat   = {imm_hi, imm_lo};
        lane_w    = 7'(MIN_LANE) << lane_sel;
        diff      = imm_cat - lane_w;
        shift_cnt = diff[CNT_W-1:0];
    end

    // Illegal when 64-bit lanes meet a narrow vector, or no size bit is set (R7)
    always_comb begin
        illegal = (imm_hi[3] && !q_full) || (imm_hi == 4'd0);
    end

    // Count must stay inside the selected lane (R2)
    always_comb begin
        if (illegal === 1'b0) begin
            assert_count_in_lane_R2: assert (diff < lane_w)
                else $error("shift count %0d outside lane %0d", diff, lane_w);
        end
    end
endmodule

// File: rtl/simd_shl_lane_array.sv
// Shifts every LANE_W-bit lane of the vector left by one common count.
// In insert mode the vacated low bits are filled from the destination.
// Assumes shift_cnt < LANE_W whenever the result is used.
module simd_shl_lane_array
    import simd_shl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic             ins_mode,
    input  logic [CNT_W-1:0] shift_cnt,
    output logic [VEC_W-1:0] res_vec
);
    localparam int NUM_LANES = VEC_W / LANE_W;

    logic [LANE_W-1:0] keep_mask;

    // Ones in the lane bits that receive shifted source data (R3, R4)
    always_comb begin
        keep_mask = {LANE_W{1'b1}} << shift_cnt;
    end

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] s_ln;
        logic [LANE_W-1:0] d_ln;
        logic [LANE_W-1:0] shifted;
        logic [LANE_W-1:0] merged;

        // Shift one lane on its own so no bit crosses its boundary (R3)
        always_comb begin
            s_ln    = src_vec[ln*LANE_W +: LANE_W];
            d_ln    = dst_vec[ln*LANE_W +: LANE_W];
            shifted = s_ln << shift_cnt;
            merged  = ins_mode ? ((shifted & keep_mask) | (d_ln & ~keep_mask))
                               : shifted;
            res_vec[ln*LANE_W +: LANE_W] = merged;
        end

        // A zero count in insert mode must hand the source lane through (R5)
        always_comb begin
            if (ins_mode === 1'b1 && shift_cnt === '0) begin
                assert_insert_zero_copy_R5: assert (merged === s_ln)
                    else $error("insert with zero count altered lane %0d", ln);
            end
        end
    end
endmodule

// File: rtl/simd_shl_out_stage.sv
// Single output register with a valid/ready handshake. It accepts a new
// entry when empty or when the current one is taken in the same cycle.
module simd_shl_out_stage #(
    parameter int DATA_W = 129
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    // Ready when the register is empty or being drained (R8)
    always_comb begin
        in_ready = !out_valid || out_ready;
    end

    // Valid flag: set on accept, cleared on drain, cleared by reset (R8, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Data register: loaded only on accept (R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid && in_ready) begin
            out_data <= in_data;
        end
    end

    // A stalled result stays put (R8)
    assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("output changed while stalled");

    // An accepted operation is visible one cycle later (R8)
    assert_one_cycle_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid)
        else $error("accepted operation did not appear");
endmodule

// File: rtl/simd_shl_insert_unit.sv
// Top level of the packed left-shift unit. It decodes the immediate,
// builds one lane array per lane size, picks the one the decode selects,
// applies narrow-vector clearing and illegal zeroing, then registers the
// result behind a valid/ready handshake.
module simd_shl_insert_unit
    import simd_shl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic             q_full,
    input  logic             ins_mode,
    input  logic [3:0]       imm_hi,
    input  logic [2:0]       imm_lo,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_result,
    output logic             out_illegal
);
    localparam int PKT_W = VEC_W + 1;

    lane_sel_e        lane_sel;
    logic [CNT_W-1:0] shift_cnt;
    logic             illegal;
    logic [VEC_W-1:0] res_by_size [NUM_SIZES];
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] shaped;
    logic [PKT_W-1:0] pkt_in;
    logic [PKT_W-1:0] pkt_out;

    simd_shl_decode u_decode (
        .imm_hi    (imm_hi),
        .imm_lo    (imm_lo),
        .q_full    (q_full),
        .lane_sel  (lane_sel),
        .shift_cnt (shift_cnt),
        .illegal   (illegal)
    );

    for (genvar sz = 0; sz < NUM_SIZES; sz++) begin : g_size
        simd_shl_lane_array #(
            .LANE_W (MIN_LANE << sz)
        ) u_lanes (
            .src_vec   (src_vec),
            .dst_vec   (dst_vec),
            .ins_mode  (ins_mode),
            .shift_cnt (shift_cnt),
            .res_vec   (res_by_size[sz])
        );
    end

    // Pick the lane array matching the decoded size (R1)
    always_comb begin
        picked = res_by_size[lane_sel];
    end

    // Clear upper half for narrow vectors, zero everything when illegal (R6, R7)
    always_comb begin
        shaped = picked;
        if (!q_full) begin
            shaped[VEC_W-1:HALF_W] = '0;
        end
        if (illegal) begin
            shaped = '0;
        end
        pkt_in = {illegal, shaped};
    end

    simd_shl_out_stage #(
        .DATA_W (PKT_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (pkt_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (pkt_out)
    );

    // Split the registered packet onto the ports
    always_comb begin
        out_illegal = pkt_out[PKT_W-1];
        out_result  = pkt_out[VEC_W-1:0];
    end

    // A flagged result carries no data (R7)
    assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0))
        else $error("illegal result not zero");

    // The input side is never ready while a stalled result is held (R8)
    assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("ready while stalled");
endmodule

// File: tb/simd_shl_insert_unit_bench.sv
module simd_shl_insert_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic         q_full = 1'b1;
    logic         ins_mode = 1'b0;
    logic [3:0]   imm_hi = 4'd1;
    logic [2:0]   imm_lo = 3'd0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_result;
    logic         out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    simd_shl_insert_unit u_simd_shl_insert_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_vec(src_vec), .dst_vec(dst_vec), .q_full(q_full),
        .ins_mode(ins_mode), .imm_hi(imm_hi), .imm_lo(imm_lo),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic bit model_illegal(logic [3:0] h, logic q);
        return (h[3] && !q) || (h == 4'd0);
    endfunction

    // Bit-level model of R1..R7
    function automatic logic [127:0] model_res(logic [127:0] s, logic [127:0] d,
            logic q, logic ins, logic [3:0] h, logic [2:0] l);
        logic [127:0] r = '0;
        int esz;
        int cnt;
        if (model_illegal(h, q)) return '0;
        esz = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
        cnt = int'({h, l}) - esz;
        for (int ln = 0; ln < 128 / esz; ln++) begin
            for (int b = 0; b < esz; b++) begin
                if (b < cnt) r[ln*esz+b] = ins ? d[ln*esz+b] : 1'b0;
                else         r[ln*esz+b] = s[ln*esz+b-cnt];
            end
        end
        if (!q) r[127:64] = '0;
        return r;
    endfunction

    task automatic check(string req, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one op, sample one cycle after acceptance
    task automatic run_op(string req, logic [127:0] s, logic [127:0] d,
            logic q, logic ins, logic [3:0] h, logic [2:0] l);
        logic [127:0] exp;
        @(negedge clk);
        src_vec = s; dst_vec = d; q_full = q; ins_mode = ins;
        imm_hi = h; imm_lo = l; in_valid = 1'b1;
        exp = model_res(s, d, q, ins, h, l);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R8 valid"}, {127'd0, out_valid}, 128'd1);
        check(req, out_result, exp);
        check({req, " R7 flag"}, {127'd0, out_illegal},
              {127'd0, model_illegal(h, q)});
    endtask

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] keep;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset ready", {127'd0, in_ready}, 128'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", {127'd0, out_valid}, 128'd0);

        a = {4{32'h8123_4567}};
        b = {4{32'hFEDC_BA98}};
        // R1/R3: 8-bit lanes, count 3 ({0001,011}=11-8)
        run_op("R1 R3 b8 cnt3", a, b, 1, 0, 4'b0001, 3'd3);
        // R3: 16-bit lanes, max count 15 ({0011,111}=31-16)
        run_op("R3 b16 cnt15", a, b, 1, 0, 4'b0011, 3'd7);
        // R2: 32-bit lanes, count 0 and count 31
        run_op("R2 b32 cnt0", a, b, 1, 0, 4'b0100, 3'd0);
        run_op("R2 b32 cnt31", a, b, 1, 0, 4'b0111, 3'd7);
        // R3: 64-bit lanes, count 40; carry must not cross lanes
        run_op("R3 b64 cnt40", {128{1'b1}}, b, 1, 0, 4'b1101, 3'd0);
        // R4: insert in each size
        run_op("R4 ins b8", a, b, 1, 1, 4'b0001, 3'd5);
        run_op("R4 ins b16", a, b, 1, 1, 4'b0010, 3'd6);
        run_op("R4 ins b32", a, b, 1, 1, 4'b0110, 3'd3);
        run_op("R4 ins b64", a, b, 1, 1, 4'b1111, 3'd7);
        // R5: insert with count 0 copies the source
        run_op("R5 ins cnt0", a, b, 1, 1, 4'b0010, 3'd0);
        check("R5 copy equals src", out_result, a);
        // R6: narrow vector clears upper half
        run_op("R6 narrow", a, b, 0, 1, 4'b0100, 3'd4);
        check("R6 upper zero", {64'd0, out_result[127:64]}, 128'd0);
        // R7: illegal encodings
        run_op("R7 b64 narrow", a, b, 0, 0, 4'b1000, 3'd1);
        run_op("R7 zero hi", a, b, 1, 1, 4'b0000, 3'd5);

        // R8: stall holds the output and blocks the input
        @(negedge clk);
        out_ready = 1'b0;
        src_vec = a; dst_vec = b; q_full = 1; ins_mode = 0;
        imm_hi = 4'b0001; imm_lo = 3'd1; in_valid = 1'b1;
        keep = model_res(a, b, 1, 0, 4'b0001, 3'd1);
        @(negedge clk);
        src_vec = b; imm_lo = 3'd2;
        check("R8 stall ready low", {127'd0, in_ready}, 128'd0);
        @(negedge clk);
        check("R8 held valid", {127'd0, out_valid}, 128'd1);
        check("R8 held data", out_result, keep);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 second op", out_result, model_res(b, b, 1, 0, 4'b0001, 3'd2));
        @(negedge clk);
        check("R8 drained", {127'd0, out_valid}, 128'd0);

        // Random mix of all modes
        for (int i = 0; i < 400; i++) begin
            logic [127:0] rs;
            logic [127:0] rd;
            rs = {$urandom, $urandom, $urandom, $urandom};
            rd = {$urandom, $urandom, $urandom, $urandom};
            run_op("R3 R4 R6 random", rs, rd, 1'($urandom), 1'($urandom),
                   4'($urandom), 3'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired got 0 expected 1");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule